// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds three alarm registers (minutes, hours, day of week) and compares them with the running time of a clock counter that lives elsewhere. The counter supplies its current minutes, hours and day as BCD values. It also supplies a level that is high while the hundredths digit reads 99, and a one-cycle strobe when the seconds wrap to 00. The alarm registers use the same BCD layout as the clock registers. The top bit of each alarm register is a mask. Together the three masks set how often the alarm repeats: on an exact minute/hour/day, once a day, once an hour, or once a minute.

A match is only considered while the hundredths window is open and the seconds wrap strobe is present. The match is remembered for that window and turns into a sticky flag on the first cycle after the window closes. While the flag is set and the interrupt enable is 1, an active-low interrupt is driven. Any read or write of an alarm register clears the flag, and with it the interrupt.

There is no streaming data path. The register bus is a plain single-cycle port: a write takes effect on the clock edge at which it is presented, and read data is valid combinationally in the cycle the read is presented. The bus never stalls, so it needs no back-pressure.

Top module: `tod_alarm_match`

## Requirements
- R1: The minutes alarm register sits at address 3 and the hours alarm register at address 5. Each stores and reads back the full 8-bit value written to it. Bit 7 of each is its mask bit.
- R2: The day alarm register sits at address 7. Bit 7 (its mask) and bits 2:0 (the day) read back as written, and bits 6:3 always read 0.
- R3: bus_rdata is 0 in every cycle that is not a read (bus_sel=1, bus_wr=0) of address 3, 5 or 7.
- R4: When the day mask is 0, a match requires all of the following, whatever the other two masks hold:
  - cur_min equals bits 6:0 of the minutes alarm;
  - cur_hour equals bits 6:0 of the hours alarm, including the 12/24 select bit and the AM/PM bit;
  - cur_day equals bits 2:0 of the day alarm.
- R5: When the day mask is 1 and the hours mask is 0, a match requires minutes and hours to match, and the day is ignored.
- R6: When the day and hours masks are 1 and the minutes mask is 0, a match requires only the minutes to match.
- R7: When all three masks are 1, every qualifying seconds wrap is a match.
- R8: A match counts only in a cycle where hund_is_99=1 and sec_wrap=1. The flag rises in the cycle after the first cycle in which hund_is_99 is 0 again. Each window produces at most one set, and the flag stays 0 until the window has closed.
- R9: The flag is sticky. A read or write of address 3, 5 or 7 clears it in the next cycle, and this clear takes precedence over a set in the same cycle.
- R10: irq_n is 0 exactly when alarm_flag=1 and int_en=1. Otherwise it is 1.
- R11: After reset, all alarm registers read 0, alarm_flag=0 and irq_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not reading an alarm register) |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours with 12/24 and AM/PM bits, BCD |
| cur_day | input | 3 | Current day of week |
| hund_is_99 | input | 1 | High while hundredths reads 99 |
| sec_wrap | input | 1 | One-cycle strobe at the seconds 59 to 00 wrap |
| int_en | input | 1 | Interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions watch, on every cycle, the following:
- that an alarm-register access clears the flag;
- that the flag stays set when nothing accesses it;
- that the flag rises only right after a window closes;
- that the day register's spare bits read 0, and that idle read data is 0;
- that irq_n stays high when the flag or the enable is low.

Only the bench scenarios can show two things. The first is that each of the eight mask combinations selects the right fields under every pattern of matching and mismatching fields. The second is that a wrap outside the window, or a window without a wrap, leaves the flag clear, and that an access in the closing cycle wins over the set.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT,
    MODE_DAILY,
    MODE_HOURLY,
    MODE_MINUTE
  } alarm_mode_e;

  typedef struct packed {
    logic min_en;
    logic hour_en;
    logic day_en;
  } cmp_sel_t;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DAY_W  = 3,
  parameter int A_MIN  = 3,
  parameter int A_HOUR = 5,
  parameter int A_DAY  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              access,
  output logic [DATA_W-1:0] min_reg,
  output logic [DATA_W-1:0] hour_reg,
  output logic              day_mask,
  output logic [DAY_W-1:0]  day_val
);
  localparam int MSB  = DATA_W - 1;
  localparam int PADW = DATA_W - 1 - DAY_W;

  logic hit_min, hit_hour, hit_day;
  logic [DATA_W-1:0] day_view;

  assign hit_min  = bus_addr == ADDR_W'(A_MIN);
  assign hit_hour = bus_addr == ADDR_W'(A_HOUR);
  assign hit_day  = bus_addr == ADDR_W'(A_DAY);
  assign access   = bus_sel && (hit_min || hit_hour || hit_day);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_reg  <= '0;
      hour_reg <= '0;
      day_mask <= 1'b0;
      day_val  <= '0;
    end else if (bus_sel && bus_wr) begin
      if (hit_min)  min_reg  <= bus_wdata;
      if (hit_hour) hour_reg <= bus_wdata;
      if (hit_day) begin
        day_mask <= bus_wdata[MSB];
        day_val  <= bus_wdata[DAY_W-1:0];
      end
    end
  end

  assign day_view = {day_mask, {PADW{1'b0}}, day_val};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_min)       bus_rdata = min_reg;
      else if (hit_hour) bus_rdata = hour_reg;
      else if (hit_day)  bus_rdata = day_view;
    end
  end
endmodule

// File: rtl/alarm_mask_decode.sv
module alarm_mask_decode
  import tod_alarm_pkg::*;
(
  input  logic     mask_min,
  input  logic     mask_hour,
  input  logic     mask_day,
  output cmp_sel_t cmp_sel
);
  alarm_mode_e mode;

  // The highest-order mask bit decides; lower masks only matter once it is set.
  always_comb begin
    if (!mask_day)       mode = MODE_EXACT;
    else if (!mask_hour) mode = MODE_DAILY;
    else if (!mask_min)  mode = MODE_HOURLY;
    else                 mode = MODE_MINUTE;
  end

  always_comb begin
    unique case (mode)
      MODE_EXACT:  cmp_sel = '{min_en: 1'b1, hour_en: 1'b1, day_en: 1'b1};
      MODE_DAILY:  cmp_sel = '{min_en: 1'b1, hour_en: 1'b1, day_en: 1'b0};
      MODE_HOURLY: cmp_sel = '{min_en: 1'b1, hour_en: 1'b0, day_en: 1'b0};
      default:     cmp_sel = '{min_en: 1'b0, hour_en: 1'b0, day_en: 1'b0};
    endcase
  end
endmodule

// File: rtl/alarm_match_timer.sv
module alarm_match_timer
  import tod_alarm_pkg::*;
#(
  parameter int TIME_W = 7,
  parameter int DAY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] cur_min,
  input  logic [TIME_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [TIME_W-1:0] alm_min,
  input  logic [TIME_W-1:0] alm_hour,
  input  logic [DAY_W-1:0]  alm_day,
  input  cmp_sel_t          cmp_sel,
  input  logic              hund_is_99,
  input  logic              sec_wrap,
  input  logic              access,
  output logic              flag
);
  logic hit, qualify, win_q, pend_q, win_end;

  assign hit = (!cmp_sel.min_en  || (cur_min  == alm_min))  &&
               (!cmp_sel.hour_en || (cur_hour == alm_hour)) &&
               (!cmp_sel.day_en  || (cur_day  == alm_day));

  assign qualify = hund_is_99 && sec_wrap && hit;
  assign win_end = win_q && !hund_is_99;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      pend_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      win_q <= hund_is_99;
      if (win_end) pend_q <= 1'b0;
      else if (qualify) pend_q <= 1'b1;
      if (access) flag <= 1'b0;
      else if (win_end && pend_q) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int TIME_W = 7,
  parameter int DAY_W  = 3,
  parameter int A_MIN  = 3,
  parameter int A_HOUR = 5,
  parameter int A_DAY  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TIME_W-1:0] cur_min,
  input  logic [TIME_W-1:0] cur_hour,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic              hund_is_99,
  input  logic              sec_wrap,
  input  logic              int_en,
  output logic              alarm_flag,
  output logic              irq_n
);
  localparam int MSB = DATA_W - 1;

  logic              access;
  logic [DATA_W-1:0] min_reg, hour_reg;
  logic              day_mask;
  logic [DAY_W-1:0]  day_val;
  cmp_sel_t          cmp_sel;

  alarm_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W),
    .A_MIN(A_MIN), .A_HOUR(A_HOUR), .A_DAY(A_DAY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .access(access), .min_reg(min_reg), .hour_reg(hour_reg),
    .day_mask(day_mask), .day_val(day_val)
  );

  alarm_mask_decode u_dec (
    .mask_min(min_reg[MSB]), .mask_hour(hour_reg[MSB]), .mask_day(day_mask),
    .cmp_sel(cmp_sel)
  );

  alarm_match_timer #(.TIME_W(TIME_W), .DAY_W(DAY_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .alm_min(min_reg[TIME_W-1:0]), .alm_hour(hour_reg[TIME_W-1:0]),
    .alm_day(day_val), .cmp_sel(cmp_sel),
    .hund_is_99(hund_is_99), .sec_wrap(sec_wrap), .access(access),
    .flag(alarm_flag)
  );

  assign irq_n = !(alarm_flag && int_en);
endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DAY_W  = 3,
  parameter int A_MIN  = 3,
  parameter int A_HOUR = 5,
  parameter int A_DAY  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              hund_is_99,
  input logic              int_en,
  input logic              alarm_flag,
  input logic              irq_n
);
  logic alm_addr, alm_access, alm_read;

  assign alm_addr   = (bus_addr == ADDR_W'(A_MIN)) || (bus_addr == ADDR_W'(A_HOUR)) ||
                      (bus_addr == ADDR_W'(A_DAY));
  assign alm_access = bus_sel && alm_addr;
  assign alm_read   = alm_access && !bus_wr;

  a_r9_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    alm_access |=> !alarm_flag);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && !alm_access |=> alarm_flag);

  a_r8_set_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> (!$past(hund_is_99) && $past(hund_is_99, 2) && !$past(alm_access)));

  a_r2_day_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(A_DAY)) |-> (bus_rdata[DATA_W-2:DAY_W] == '0));

  a_r3_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_read |-> (bus_rdata == '0));

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en || !alarm_flag) |-> irq_n);
endmodule

bind tod_alarm_match tod_alarm_match_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W),
  .A_MIN(A_MIN), .A_HOUR(A_HOUR), .A_DAY(A_DAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .hund_is_99(hund_is_99),
  .int_en(int_en), .alarm_flag(alarm_flag), .irq_n(irq_n)
);

// File: tb/tod_alarm_match_test.sv
module tod_alarm_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] cur_min = '0, cur_hour = '0;
  logic [2:0] cur_day = '0;
  logic       hund_is_99 = 1'b0, sec_wrap = 1'b0, int_en = 1'b0;
  logic       alarm_flag, irq_n;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  localparam logic [6:0] AMIN = 7'h45, BMIN = 7'h44;
  localparam logic [6:0] AHR  = 7'h52, BHR  = 7'h72;
  localparam logic [2:0] ADAY = 3'd3,  BDAY = 3'd5;

  always #10 clk = ~clk;

  tod_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .hund_is_99(hund_is_99), .sec_wrap(sec_wrap), .int_en(int_en),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // One hundredths window of a single cycle; returns at the negedge after the flag could rise.
  task automatic window(input logic [6:0] m, input logic [6:0] h, input logic [2:0] dy,
                        input logic wrap);
    @(negedge clk);
    cur_min = m; cur_hour = h; cur_day = dy; hund_is_99 = 1'b1; sec_wrap = wrap;
    @(negedge clk);
    hund_is_99 = 1'b0; sec_wrap = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 flag", {7'd0, alarm_flag}, 8'd0);
    check("R11 irq_n", {7'd0, irq_n}, 8'd1);
    rd_reg(4'd3, rd); check("R11 min reg", rd, 8'h00);
    rd_reg(4'd5, rd); check("R11 hour reg", rd, 8'h00);
    rd_reg(4'd7, rd); check("R11 day reg", rd, 8'h00);

    // R1 / R2 register storage
    wr_reg(4'd3, 8'hA7); rd_reg(4'd3, rd); check("R1 min readback", rd, 8'hA7);
    wr_reg(4'd5, 8'hD2); rd_reg(4'd5, rd); check("R1 hour readback", rd, 8'hD2);
    wr_reg(4'd7, 8'hFF); rd_reg(4'd7, rd); check("R2 day spare bits", rd, 8'h87);
    wr_reg(4'd7, 8'h7A); rd_reg(4'd7, rd); check("R2 day value", rd, 8'h02);
    // R3 non-alarm addresses read 0
    for (int a = 0; a < 16; a++) begin
      if (a != 3 && a != 5 && a != 7) begin
        rd_reg(4'(a), rd); check("R3 other address", rd, 8'h00);
      end
    end
    #1 check("R3 idle bus", bus_rdata, 8'h00);

    // R4..R7 sweep: every mask combination against every field-match pattern
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic md, mh, mm, exp;
        string tag;
        md = m[2]; mh = m[1]; mm = m[0];
        wr_reg(4'd3, {mm, AMIN});
        wr_reg(4'd5, {mh, AHR});
        wr_reg(4'd7, {md, 4'b0000, ADAY});
        exp = (!(md && mh && mm) ? p[0] : 1'b1) &&
              (!(md && mh)       ? p[1] : 1'b1) &&
              (!md               ? p[2] : 1'b1);
        if (!md) tag = "R4";
        else if (!mh) tag = "R5";
        else if (!mm) tag = "R6";
        else tag = "R7";
        window(p[0] ? AMIN : BMIN, p[1] ? AHR : BHR, p[2] ? ADAY : BDAY, 1'b1);
        check($sformatf("%s mask=%0d pat=%0d", tag, m, p), {7'd0, alarm_flag}, {7'd0, exp});
        rd_reg(4'd3, rd);
        check("R9 read clears", {7'd0, alarm_flag}, 8'd0);
      end
    end

    // Exact alarm for the remaining scenarios
    wr_reg(4'd3, {1'b0, AMIN}); wr_reg(4'd5, {1'b0, AHR}); wr_reg(4'd7, {5'd0, ADAY});

    // R8: no wrap inside window -> nothing
    window(AMIN, AHR, ADAY, 1'b0);
    check("R8 window without wrap", {7'd0, alarm_flag}, 8'd0);
    // R8: wrap outside window -> nothing
    @(negedge clk); sec_wrap = 1'b1; @(negedge clk); sec_wrap = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 wrap outside window", {7'd0, alarm_flag}, 8'd0);
    // R8: flag stays low while window still open, rises after it closes
    @(negedge clk); hund_is_99 = 1'b1; sec_wrap = 1'b1;
    @(negedge clk); sec_wrap = 1'b0;
    check("R8 open window", {7'd0, alarm_flag}, 8'd0);
    @(negedge clk); hund_is_99 = 1'b0;
    check("R8 still open", {7'd0, alarm_flag}, 8'd0);
    @(negedge clk);
    check("R8 rise after close", {7'd0, alarm_flag}, 8'd1);

    // R10 interrupt gating
    int_en = 1'b0; #1 check("R10 disabled", {7'd0, irq_n}, 8'd1);
    int_en = 1'b1; #1 check("R10 enabled", {7'd0, irq_n}, 8'd0);
    // R9 sticky through idle cycles and non-matching windows
    repeat (5) @(negedge clk);
    window(BMIN, BHR, BDAY, 1'b1);
    check("R9 sticky", {7'd0, alarm_flag}, 8'd1);
    // R9 write clears
    wr_reg(4'd7, {5'd0, ADAY});
    check("R9 write clears", {7'd0, alarm_flag}, 8'd0);
    #1 check("R10 irq released", {7'd0, irq_n}, 8'd1);

    // R9 access in the closing cycle beats the set
    @(negedge clk); cur_min = AMIN; cur_hour = AHR; cur_day = ADAY;
    hund_is_99 = 1'b1; sec_wrap = 1'b1;
    @(negedge clk); hund_is_99 = 1'b0; sec_wrap = 1'b0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd5;
    @(negedge clk); bus_sel = 1'b0;
    check("R9 clear beats set", {7'd0, alarm_flag}, 8'd0);
    repeat (2) @(negedge clk);
    check("R8 single set per window", {7'd0, alarm_flag}, 8'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule